// File: doc/BRIEF.md
# Serial flash transfer length controller

This block sets how many data bytes a single command phase of a serial flash controller moves, and marks the end of that phase. Software keeps the byte count, minus one, in a 32-bit length register. That register can only be changed while no transfer is in flight. A start pulse loads a down-counter from the resolved length. The shifting logic then reports every completed byte with a one-cycle strobe. When the last byte arrives, the block drops busy and pulses done.

The stored length is treated differently in each of four functional modes. In the two indirect modes it is normally a plain count. The all-ones value is a sentinel instead: the transfer runs from the start address to the top of a power-of-two memory window, whose size comes from a 5-bit size code. The largest window never ends. In status-polling mode the count is capped at four bytes, and a sticky error flag records each cap. In memory-mapped mode the length plays no part, and the phase runs until it is aborted.

Top module: `flash_len_ctrl`

## Requirements
- R1: After reset, len_o is 0, and busy_o, done_o and cfg_err_o are low.
- R2: A pulse on len_we_i while busy_o is low stores len_wdata_i, and len_o shows it from the next cycle. A write while busy_o is high is ignored and len_o keeps its value.
- R3: mode_i encodes 2'b00 indirect write, 2'b01 indirect read, 2'b10 memory-mapped and 2'b11 status polling. In an indirect mode with a stored length L other than all ones, a start accepted while idle raises busy_o on the next cycle. After exactly L+1 byte strobes, busy_o falls and done_o rises in the cycle after the last strobe.
- R4: done_o is high for a single cycle per completed transfer.
- R5: In an indirect mode with a stored length of 0xFFFFFFFF, the transfer moves 2^(S+1) - (A mod 2^(S+1)) bytes. Here S is size_i and A is start_addr_i, both sampled at the start.
- R6: With size_i = 31 and a stored length of all ones in an indirect mode, busy_o stays high for any number of strobes and done_o never rises.
- R7: In memory-mapped mode (2'b10) the stored length has no effect: busy_o stays high for any number of strobes and done_o never rises.
- R8: In status-polling mode (2'b11), a stored length of 3 or less moves L+1 bytes and leaves cfg_err_o unchanged.
- R9: In status-polling mode, a stored length above 3 moves exactly 4 bytes and sets cfg_err_o. cfg_err_o then stays high until reset.
- R10: abort_i clears busy_o on the next cycle, with no done_o pulse. It takes priority over a strobe or a start in the same cycle.
- R11: A start pulse while busy_o is high is ignored: the transfer in flight keeps its remaining count.
- R12: Byte strobes while idle have no effect: busy_o and done_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_we_i | input | 1 | Length register write strobe |
| len_wdata_i | input | 32 | Length write data (byte count minus one) |
| len_o | output | 32 | Stored length value |
| mode_i | input | 2 | Functional mode, sampled at start |
| size_i | input | 5 | Memory window code, window = 2^(size_i+1) bytes |
| start_addr_i | input | 32 | Transfer start address, sampled at start |
| start_i | input | 1 | Start pulse |
| byte_i | input | 1 | One data byte moved |
| abort_i | input | 1 | Abort the transfer in flight |
| busy_o | output | 1 | Transfer in flight |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err_o | output | 1 | Sticky: polling length was capped |

## Verification
The bench builds the block with its default parameters: a 32-bit length and address and a 5-bit size code. With these defaults the all-ones length sentinel and the size code 31, which never terminates, can both be reached. Small size codes combined with chosen address offsets give end-of-window counts of one to a few bytes, so the span arithmetic is checked at both edges without long runs. The polling cap is checked on both sides of the limit of four.

// File: rtl/flen_pkg.sv
package flen_pkg;
  typedef enum logic [1:0] {
    MODE_IND_WR = 2'b00,
    MODE_IND_RD = 2'b01,
    MODE_MMAP   = 2'b10,
    MODE_POLL   = 2'b11
  } xfer_mode_e;

  localparam int POLL_MAX_M1 = 3;  // polling phase carries at most 4 bytes
endpackage

// File: rtl/flen_len_reg.sv
module flen_len_reg #(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LEN_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              len_q <= '0;
    else if (we_i && !busy_i) len_q <= wdata_i;
  end

  assign len_o = len_q;

  assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(len_q));
  assert_idle_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !busy_i) |=> (len_q == $past(wdata_i)));
endmodule

// File: rtl/flen_span.sv
// Bytes from start address to top of a 2^(size+1) window, minus one.
module flen_span #(
  parameter int LEN_W  = 32,
  parameter int SIZE_W = 5
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  addr_i,
  output logic [LEN_W-1:0]  span_o,
  output logic              endless_o
);
  logic [LEN_W-1:0] mask;

  for (genvar g = 0; g < LEN_W; g++) begin : g_mask
    assign mask[g] = (int'(size_i) >= g);
  end

  // window - (addr mod window) - 1 == ~addr within the window bits
  assign span_o    = mask & ~addr_i;
  assign endless_o = (int'(size_i) + 1 >= LEN_W);
endmodule

// File: rtl/flen_resolve.sv
module flen_resolve
  import flen_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int SIZE_W = 5
) (
  input  logic [LEN_W-1:0]  len_i,
  input  xfer_mode_e        mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  addr_i,
  output logic [LEN_W-1:0]  load_o,
  output logic              free_run_o,
  output logic              clamp_o
);
  localparam logic [LEN_W-1:0] POLL_CAP = LEN_W'(POLL_MAX_M1);

  logic [LEN_W-1:0] span;
  logic             endless;
  logic             all_ones;

  flen_span #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_span (
    .size_i   (size_i),
    .addr_i   (addr_i),
    .span_o   (span),
    .endless_o(endless)
  );

  assign all_ones = &len_i;

  always_comb begin
    load_o     = len_i;
    free_run_o = 1'b0;
    clamp_o    = 1'b0;
    unique case (mode_i)
      MODE_MMAP: begin
        load_o     = '0;
        free_run_o = 1'b1;
      end
      MODE_POLL: begin
        if (len_i > POLL_CAP) begin
          load_o  = POLL_CAP;
          clamp_o = 1'b1;
        end
      end
      default: begin
        if (all_ones) begin
          load_o     = span;
          free_run_o = endless;
        end
      end
    endcase
  end

  always_comb begin
    if (mode_i == MODE_POLL) assert_poll_cap_R9: assert (load_o <= POLL_CAP);
  end
endmodule

// File: rtl/flen_counter.sv
module flen_counter #(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] load_i,
  input  logic             free_run_i,
  input  logic             byte_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             busy_q, done_q, free_q;
  logic             last;

  assign last = busy_q && byte_i && !free_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      free_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      free_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= load_i;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      free_q <= free_run_i;
    end else if (last) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (busy_q && byte_i && !free_q) cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_abort_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_q && !done_q));
  assert_free_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && free_q && !abort_i) |=> (busy_q && !done_q));
  assert_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !byte_i && !abort_i) |=> (busy_q && $stable(cnt_q)));
  assert_idle_byte_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && byte_i && !start_i) |=> (!busy_q && !done_q));
endmodule

// File: rtl/flash_len_ctrl.sv
module flash_len_ctrl
  import flen_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int SIZE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              len_we_i,
  input  logic [LEN_W-1:0]  len_wdata_i,
  output logic [LEN_W-1:0]  len_o,
  input  logic [1:0]        mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  start_addr_i,
  input  logic              start_i,
  input  logic              byte_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  xfer_mode_e       mode;
  logic [LEN_W-1:0] len_val;
  logic [LEN_W-1:0] load_val;
  logic             free_run, clamp, start_ok;
  logic             cfg_err_q;

  assign mode     = xfer_mode_e'(mode_i);
  assign start_ok = start_i && !busy_o && !abort_i;

  flen_len_reg #(.LEN_W(LEN_W)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (len_we_i),
    .wdata_i(len_wdata_i),
    .busy_i (busy_o),
    .len_o  (len_val)
  );

  flen_resolve #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_res (
    .len_i     (len_val),
    .mode_i    (mode),
    .size_i    (size_i),
    .addr_i    (start_addr_i),
    .load_o    (load_val),
    .free_run_o(free_run),
    .clamp_o   (clamp)
  );

  flen_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .load_i    (load_val),
    .free_run_i(free_run),
    .byte_i    (byte_i),
    .abort_i   (abort_i),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_err_q <= 1'b0;
    else if (start_ok && clamp) cfg_err_q <= 1'b1;
  end

  assign len_o     = len_val;
  assign cfg_err_o = cfg_err_q;

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_q |=> cfg_err_q);
  assert_poll_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && mode_i == 2'b11 && len_val > LEN_W'(POLL_MAX_M1)) |=> cfg_err_q);
  assert_poll_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_q && start_ok && mode_i == 2'b11 && len_val <= LEN_W'(POLL_MAX_M1))
      |=> !cfg_err_q);
endmodule

// File: tb/sim_flash_len_ctrl.sv
module sim_flash_len_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_we = 1'b0;
  logic [31:0] len_wdata = '0;
  logic [31:0] len_q;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  size = '0;
  logic [31:0] addr = '0;
  logic        start = 1'b0, byte_s = 1'b0, abort = 1'b0;
  logic        busy, done, cfg_err;

  int checks = 0, failures = 0;
  int exp_q[$];
  int seen = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  flash_len_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .len_we_i(len_we), .len_wdata_i(len_wdata),
    .len_o(len_q), .mode_i(mode), .size_i(size), .start_addr_i(addr),
    .start_i(start), .byte_i(byte_s), .abort_i(abort),
    .busy_o(busy), .done_o(done), .cfg_err_o(cfg_err)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: count accepted strobes, compare at done against scoreboard
  always @(posedge clk) begin
    if (start && !busy && !abort) seen = 0;
    else if (byte_s && busy) seen++;
  end

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) check(0, "R3", "unexpected done", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(seen == e, "R3", "bytes at done", seen, e);
      end
    end
  end

  task automatic write_len(logic [31:0] v);
    @(negedge clk); len_we = 1'b1; len_wdata = v;
    @(negedge clk); len_we = 1'b0;
  endtask

  task automatic start_xfer(logic [1:0] m, logic [4:0] s, logic [31:0] a);
    @(negedge clk); mode = m; size = s; addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_s = 1'b1;
    end
    @(negedge clk); byte_s = 1'b0;
  endtask

  task automatic do_abort(bit with_byte);
    @(negedge clk); abort = 1'b1; byte_s = with_byte;
    @(negedge clk); abort = 1'b0; byte_s = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      check(0, "WDOG", "watchdog expired", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(len_q == 0, "R1", "len after reset", len_q, 0);
    check({busy, done, cfg_err} == 3'b000, "R1", "flags after reset", {busy, done, cfg_err}, 0);

    // R2 idle write, R3 indirect read, R11 start while busy
    write_len(32'd4);
    check(len_q == 4, "R2", "idle write", len_q, 4);
    exp_q.push_back(5);
    start_xfer(2'b01, 5'd0, 32'h0);
    check(busy == 1, "R3", "busy after start", busy, 1);
    strobes(2);
    write_len(32'd9);
    check(len_q == 4, "R2", "write while busy ignored", len_q, 4);
    start_xfer(2'b01, 5'd0, 32'h0);
    check(busy == 1, "R11", "restart ignored keeps busy", busy, 1);
    strobes(3);
    check(busy == 0, "R3", "busy cleared after last byte", busy, 0);
    check(done == 1, "R3", "done after last byte", done, 1);
    @(negedge clk);
    check(done == 0, "R4", "done single cycle", done, 0);

    // R3 single byte, indirect write
    write_len(32'd0);
    exp_q.push_back(1);
    start_xfer(2'b00, 5'd0, 32'h0);
    strobes(1);
    check(busy == 0, "R3", "one byte transfer ends", busy, 0);

    // R12 idle strobes
    strobes(3);
    check(busy == 0 && done == 0, "R12", "idle strobes", {busy, done}, 0);

    // R5 end-of-window counts
    write_len(32'hFFFF_FFFF);
    begin
      logic [4:0]  sz[3] = '{5'd3, 5'd0, 5'd0};
      logic [31:0] ad[3] = '{32'h0000_100B, 32'h0000_0010, 32'h0000_0011};
      for (int k = 0; k < 3; k++) begin
        longint win, e;
        win = longint'(1) << (sz[k] + 1);
        e = win - (ad[k] % win);
        exp_q.push_back(int'(e));
        start_xfer(2'b01, sz[k], ad[k]);
        strobes(int'(e));
        check(busy == 0, "R5", "window end reached", busy, 0);
      end
    end

    // R6 endless window, R10 abort
    start_xfer(2'b01, 5'd31, 32'h0000_0040);
    strobes(50);
    check(busy == 1, "R6", "endless still busy", busy, 1);
    do_abort(1'b0);
    check(busy == 0 && done == 0, "R10", "abort of endless", {busy, done}, 0);

    // R7 memory-mapped ignores length
    write_len(32'd0);
    start_xfer(2'b10, 5'd2, 32'h0);
    strobes(10);
    check(busy == 1, "R7", "mmap ignores length", busy, 1);
    do_abort(1'b1);
    check(busy == 0 && done == 0, "R10", "abort beats strobe", {busy, done}, 0);

    // R10 abort mid indirect transfer
    write_len(32'd7);
    start_xfer(2'b01, 5'd0, 32'h0);
    strobes(3);
    do_abort(1'b0);
    check(busy == 0, "R10", "abort mid transfer", busy, 0);
    check(len_q == 7, "R10", "length kept after abort", len_q, 7);

    // R8 polling in range
    write_len(32'd2);
    exp_q.push_back(3);
    start_xfer(2'b11, 5'd0, 32'h0);
    strobes(3);
    check(cfg_err == 0, "R8", "no error in range", cfg_err, 0);
    check(busy == 0, "R8", "polling 3 bytes ends", busy, 0);

    // R9 polling clamp and sticky error
    write_len(32'd10);
    exp_q.push_back(4);
    start_xfer(2'b11, 5'd0, 32'h0);
    check(cfg_err == 1, "R9", "error on clamp", cfg_err, 1);
    strobes(4);
    check(busy == 0, "R9", "clamped to 4 bytes", busy, 0);
    write_len(32'd1);
    exp_q.push_back(2);
    start_xfer(2'b01, 5'd0, 32'h0);
    strobes(2);
    check(cfg_err == 1, "R9", "error sticky", cfg_err, 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3", "all expected dones seen", exp_q.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule